// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous static memory with a small parameterised array and the cycle logic of a pipelined burst cache RAM. Two active-low address strobes can open a transfer: one meant for a processor, one for a cache controller. Each follows its own priority and its own rule for when the write enables count. After a transfer has opened, a burst-advance input either steps an internal burst counter or holds it. The counter supplies the low address bits. The write enables select a read or a write on every continuing cycle.

Read data passes through two registers before it reaches the outputs. The tri-state data bus is split into an input bus, an output bus and a drive-enable flag. The drive-enable flag stands in for the buffer control: it combines the asynchronous output enable, the sleep input and the pipeline's own valid flag. A sleep input halts all activity and keeps the stored words. After wake-up, both strobes are locked out for a short recovery window.

Top module: `psb_sram`

## Requirements
- R1: With `strb_proc_n` low, `sel_a_n` low and no recovery lockout, a new transfer opens at `addr` and is always a read. This holds whatever `strb_ctl_n`, `gwe_n`, `bwe_n`, `bye_n` and `adv_n` are doing on that edge.
- R2: `strb_ctl_n` opens a transfer only while the processor strobe is high or blocked. The write enables are sampled on that same edge, so a write happens when any lane enable results from the decode of R5, and a read happens otherwise.
- R3: `sel_a_n` high blocks the processor strobe. A strobe that opens a transfer while the three selects are not all active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) deselects the device. No data is returned, and later non-strobe cycles do nothing until a new transfer opens.
- R4: On a cycle with no accepted strobe and a transfer open, `adv_n` low steps the 2-bit counter by one and `adv_n` high reuses the current address. The low two address bits are the start value plus the counter, modulo 4. The upper bits stay those of the start address.
- R5: `gwe_n` low writes every lane. Otherwise, with `bwe_n` low, lane i is written when `bye_n[i]` is low. Lane i is `din[i*BYTE_W +: BYTE_W]`, and its top bit is the parity bit. If no lane is selected, the cycle is a read.
- R6: A read sampled on edge k drives its word on `dout` after edge k+1, until edge k+2.
- R7: `dout_en` is low while `oe_n` is high, and also when the pipeline stage holds no read (write, deselect, idle). While `dout_en` is low, `dout` is zero.
- R8: On every edge with `sleep` high, no access takes place, and the array and the burst position are kept. `dout_en` is low at once. On the first 2 edges after `sleep` falls, both strobes are ignored.
- R9: A read on the cycle right after a write to the same address returns the bytes just written, merged with the bytes that were kept.
- R10: A synchronous active-low reset clears the open transfer and both pipeline valid flags, and leaves the array untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address loaded by an accepted strobe |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary select, active low, also gates the processor strobe |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| gwe_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Per-lane write qualifier, active low |
| bye_n | input | BYTES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
On every cycle, the checker confirms three things. The output enable and the sleep input always silence the bus. A processor-strobe start always yields a driven word two edges later unless the output enable forbids it. Controller-strobe writes and deselecting strobes never produce driven data. Some behaviours only the bench scenarios can show, because they need the stored contents to be tracked. These are the data values themselves, the counter's wrap within a four-word block, suspend repeats, masked lane merges, pass-through on a read after a write, the retained array across reset and sleep, and which strobe edges are ignored during the recovery window.

// File: rtl/psb_pkg.sv
package psb_pkg;

   // kind of array access decided on one clock edge
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
   import psb_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BYTES     = 4,
   parameter int BURST_LEN = 4,
   parameter int WAKE_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              strb_proc_n,
   input  logic              strb_ctl_n,
   input  logic              adv_n,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              gwe_n,
   input  logic              bwe_n,
   input  logic [BYTES-1:0]  bye_n,
   input  logic              sleep,
   output acc_kind_e         kind_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [BYTES-1:0]  lane_we_o
);

   localparam int CNT_W = $clog2(BURST_LEN);
   localparam int WK_W  = $clog2(WAKE_CYC + 1);

   logic              open_q, open_d;
   logic [ADDR_W-1:0] base_q, base_d;
   logic [CNT_W-1:0]  cnt_q,  cnt_d;
   logic [WK_W-1:0]   wk_q,   wk_d;

   logic             sel_ok;
   logic             lockout;
   logic             proc_go;
   logic             ctl_go;
   logic [BYTES-1:0] wmask;
   logic             any_wr;

   assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;
   assign lockout = (wk_q != '0);
   // processor strobe is gated by the primary select only
   assign proc_go = !strb_proc_n && !sel_a_n && !lockout;
   // controller strobe yields to an accepted processor strobe
   assign ctl_go  = !strb_ctl_n && (strb_proc_n || sel_a_n) && !lockout;

   // per-lane write decode
   for (genvar g = 0; g < BYTES; g++) begin : g_lane_dec
      assign wmask[g] = !gwe_n || (!bwe_n && !bye_n[g]);
   end
   assign any_wr = |wmask;

   function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [CNT_W-1:0]  step);
      logic [ADDR_W-1:0] a;
      a            = base;
      a[CNT_W-1:0] = base[CNT_W-1:0] + step;
      return a;
   endfunction

   always_comb begin
      open_d     = open_q;
      base_d     = base_q;
      cnt_d      = cnt_q;
      kind_o     = ACC_IDLE;
      acc_addr_o = burst_addr(base_q, cnt_q);
      lane_we_o  = '0;
      if (sleep) begin
         // everything frozen while asleep
      end else if (proc_go || ctl_go) begin
         open_d     = sel_ok;
         base_d     = addr_i;
         cnt_d      = '0;
         acc_addr_o = addr_i;
         if (sel_ok) begin
            if (ctl_go && any_wr) begin
               kind_o    = ACC_WRITE;
               lane_we_o = wmask;
            end else begin
               kind_o    = ACC_READ;
            end
         end
      end else if (open_q) begin
         cnt_d      = cnt_q + CNT_W'(!adv_n);
         acc_addr_o = burst_addr(base_q, cnt_d);
         if (any_wr) begin
            kind_o    = ACC_WRITE;
            lane_we_o = wmask;
         end else begin
            kind_o    = ACC_READ;
         end
      end
   end

   always_comb begin
      if (sleep)        wk_d = WK_W'(WAKE_CYC);
      else if (lockout) wk_d = wk_q - 1'b1;
      else              wk_d = wk_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
         wk_q   <= '0;
      end else begin
         open_q <= open_d;
         base_q <= base_d;
         cnt_q  <= cnt_d;
         wk_q   <= wk_d;
      end
   end

endmodule

// File: rtl/psb_array.sv
module psb_array
   import psb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  acc_kind_e               kind_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [BYTES-1:0]        lane_we_i,
   input  logic [BYTES*BYTE_W-1:0] din_i,
   output logic [BYTES*BYTE_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   // one storage column per byte lane, parity bit included
   for (genvar g = 0; g < BYTES; g++) begin : g_col
      logic [BYTE_W-1:0] col [DEPTH];

      always_ff @(posedge clk) begin
         if (kind_i == ACC_WRITE && lane_we_i[g]) begin
            col[addr_i] <= din_i[g*BYTE_W +: BYTE_W];
         end
      end

      assign rdata_o[g*BYTE_W +: BYTE_W] = col[addr_i];
   end

endmodule

// File: rtl/psb_outpipe.sv
module psb_outpipe #(
   parameter int DATA_W    = 36,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_vld_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   logic              cap_vld, out_vld;
   logic [DATA_W-1:0] cap_dat, out_dat;

   // stage one: capture of the addressed word
   always_ff @(posedge clk) begin
      if (!rst_n) cap_vld <= 1'b0;
      else        cap_vld <= rd_vld_i;
   end
   always_ff @(posedge clk) cap_dat <= rd_data_i;

   // stage two: output register
   always_ff @(posedge clk) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= cap_vld;
   end
   always_ff @(posedge clk) out_dat <= cap_dat;

   assign dout_en = out_vld && !oe_n && !sleep;

   if (PARK_ZERO) begin : g_park_zero
      assign dout = dout_en ? out_dat : '0;
   end else begin : g_park_hold
      assign dout = out_dat & {DATA_W{dout_en}};
   end

endmodule

// File: rtl/psb_sram.sv
module psb_sram
   import psb_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BYTES     = 4,
   parameter int BYTE_W    = 9,
   parameter int BURST_LEN = 4,
   parameter int WAKE_CYC  = 2,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    strb_proc_n,
   input  logic                    strb_ctl_n,
   input  logic                    adv_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    gwe_n,
   input  logic                    bwe_n,
   input  logic [BYTES-1:0]        bye_n,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic [BYTES*BYTE_W-1:0] din,
   output logic [BYTES*BYTE_W-1:0] dout,
   output logic                    dout_en
);

   localparam int DATA_W = BYTES * BYTE_W;
   localparam int CNT_W  = $clog2(BURST_LEN);

   // elaboration-time parameter checks
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the burst counter width");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_lane
      $error("BYTES and BYTE_W must be positive");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("WAKE_CYC must be at least 1");
   end

   acc_kind_e         kind;
   logic [ADDR_W-1:0] acc_addr;
   logic [BYTES-1:0]  lane_we;
   logic [DATA_W-1:0] rdata;

   psb_ctrl #(
      .ADDR_W   (ADDR_W),
      .BYTES    (BYTES),
      .BURST_LEN(BURST_LEN),
      .WAKE_CYC (WAKE_CYC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr),
      .strb_proc_n(strb_proc_n),
      .strb_ctl_n (strb_ctl_n),
      .adv_n      (adv_n),
      .sel_a_n    (sel_a_n),
      .sel_b      (sel_b),
      .sel_c_n    (sel_c_n),
      .gwe_n      (gwe_n),
      .bwe_n      (bwe_n),
      .bye_n      (bye_n),
      .sleep      (sleep),
      .kind_o     (kind),
      .acc_addr_o (acc_addr),
      .lane_we_o  (lane_we)
   );

   psb_array #(
      .ADDR_W(ADDR_W),
      .BYTES (BYTES),
      .BYTE_W(BYTE_W)
   ) u_array (
      .clk      (clk),
      .kind_i   (kind),
      .addr_i   (acc_addr),
      .lane_we_i(lane_we),
      .din_i    (din),
      .rdata_o  (rdata)
   );

   psb_outpipe #(
      .DATA_W   (DATA_W),
      .PARK_ZERO(PARK_ZERO)
   ) u_outpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_vld_i (kind == ACC_READ),
      .rd_data_i(rdata),
      .oe_n     (oe_n),
      .sleep    (sleep),
      .dout     (dout),
      .dout_en  (dout_en)
   );

endmodule

// File: rtl/psb_sram_chk.sv
module psb_sram_chk #(
   parameter int WAKE_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic strb_proc_n,
   input logic strb_ctl_n,
   input logic sel_a_n,
   input logic sel_b,
   input logic sel_c_n,
   input logic gwe_n,
   input logic oe_n,
   input logic sleep,
   input logic dout_en
);

   localparam int WK_W = $clog2(WAKE_CYC + 1);

   // recovery window tracked independently at the ports
   logic [WK_W-1:0] rec_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)              rec_cnt <= '0;
      else if (sleep)          rec_cnt <= WK_W'(WAKE_CYC);
      else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
   end

   logic all_sel, ready, p_start, c_start;
   assign all_sel = !sel_a_n && sel_b && !sel_c_n;
   assign ready   = (rec_cnt == '0) && !sleep;
   assign p_start = ready && !strb_proc_n && !sel_a_n;
   assign c_start = ready && !strb_ctl_n && (strb_proc_n || sel_a_n);

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);                                           // R7
   AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en);                                          // R8
   AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (p_start && all_sel) |=> ##1 (dout_en || oe_n || sleep));     // R1
   AST_CTL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (c_start && all_sel && !gwe_n) |=> ##1 !dout_en);             // R2
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((p_start || c_start) && !all_sel) |=> ##1 !dout_en);         // R3

endmodule

bind psb_sram psb_sram_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strb_proc_n(strb_proc_n),
   .strb_ctl_n (strb_ctl_n),
   .sel_a_n    (sel_a_n),
   .sel_b      (sel_b),
   .sel_c_n    (sel_c_n),
   .gwe_n      (gwe_n),
   .oe_n       (oe_n),
   .sleep      (sleep),
   .dout_en    (dout_en)
);

// File: tb/psb_sram_bench.sv
module psb_sram_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int DW = 36;

   typedef struct packed {
      logic          pn;
      logic          cn;
      logic          adv;
      logic          s1n;
      logic          gwn;
      logic          bwn;
      logic [NB-1:0] ben;
      logic          oen;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          xen;
      logic [DW-1:0] xd;
      logic [3:0]    rq;
   } vec_t;

   localparam logic [DW-1:0] D0 = 36'h123456789;
   localparam logic [DW-1:0] D1 = 36'h9ABCDEF01;
   localparam logic [DW-1:0] D2 = 36'h2468ACE13;
   localparam logic [DW-1:0] D3 = 36'h13579BDF0;
   localparam logic [DW-1:0] ONES = '1;
   // lanes 1 and 3 overwritten with ones, lanes 0 and 2 kept
   localparam logic [DW-1:0] W9 = D3 | {9'h1FF, 9'h000, 9'h1FF, 9'h000};

   localparam vec_t IDLE_RD = '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b0,36'd0,4'd0};

   localparam vec_t TBL [16] = '{
      '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,6'd10,D0,1'b0,36'd0,4'd2},     // R2 controller write, addr 10
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b1,6'd0,D1,1'b0,36'd0,4'd4},      // R4 step to 11
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b1,6'd0,D2,1'b0,36'd0,4'd4},      // R4 wrap to 8
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b1,6'd0,D3,1'b0,36'd0,4'd4},      // R4 step to 9
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'd10,36'd0,1'b0,36'd0,4'd1},  // R1 proc read, write ignored
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,D0,4'd6},      // R6 latency, read 11
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,D1,4'd4},      // R4 suspend at 11
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,D1,4'd4},      // R4 suspend repeat, step to 8
      '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0101,1'b0,6'd0,ONES,1'b1,D2,4'd5},    // R5 lanes 1,3 write at 9
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b0,36'd0,4'd7},   // R7 write gives no drive
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,W9,4'd9},      // R9 pass-through merge
      '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,1'b0,6'd10,36'd0,1'b1,W9,4'd5},     // R5 no lane => read
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,D0,4'd5},      // R5 read of 10
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'd0,36'd0,1'b0,36'd0,4'd7},   // R7 oe_n high
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,6'd8,36'd0,1'b1,D0,4'd3},      // R3 proc blocked, step to 11
      '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'd0,36'd0,1'b1,D1,4'd3}       // R3 confirms 11, not 8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          strb_proc_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
   logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
   logic          gwe_n = 1'b1, bwe_n = 1'b1;
   logic [NB-1:0] bye_n = '1;
   logic          oe_n = 1'b1, sleep = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   psb_sram u_psb_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .gwe_n(gwe_n), .bwe_n(bwe_n), .bye_n(bye_n),
      .oe_n(oe_n), .sleep(sleep), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic put(input vec_t v);
      strb_proc_n = v.pn;  strb_ctl_n = v.cn;  adv_n = v.adv;
      sel_a_n = v.s1n;     gwe_n = v.gwn;      bwe_n = v.bwn;
      bye_n = v.ben;       oe_n = v.oen;       addr = v.a;
      din = v.d;
   endtask

   task automatic check(input logic xen, input logic [DW-1:0] xd,
                        input int rq, input string what);
      logic [DW-1:0] exp_d;
      exp_d = xen ? xd : '0;
      total++;
      if (dout_en !== xen || dout !== exp_d) begin
         bad++;
         $display("FAIL R%0d %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                  rq, what, dout_en, dout, xen, exp_d);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, sample at the next falling edge
   task automatic step(input vec_t v, input logic xen, input logic [DW-1:0] xd,
                       input int rq, input string what);
      put(v);
      @(posedge clk);
      @(negedge clk);
      check(xen, xd, rq, what);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R0 watchdog expired: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      put(IDLE_RD);
      oe_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(1'b0, '0, 10, "R10 reset state");
      rst_n = 1'b1;

      for (int i = 0; i < 16; i++) begin
         put(TBL[i]);
         @(posedge clk);
         @(negedge clk);
         check(TBL[i].xen, TBL[i].xd, TBL[i].rq, $sformatf("table row %0d", i));
      end

      // R3: controller strobe with primary select high deselects
      v = IDLE_RD; v.cn = 1'b0; v.s1n = 1'b1;
      step(v, 1'b1, D1, 4, "R4 suspend read still drains");
      v = IDLE_RD; v.adv = 1'b0;
      step(v, 1'b0, '0, 3, "R3 deselect returns nothing");
      step(IDLE_RD, 1'b0, '0, 3, "R3 burst closed after deselect");

      // R10: reset mid-burst clears pipeline and burst, not the array
      v = IDLE_RD; v.pn = 1'b0; v.a = 6'd10;
      step(v, 1'b0, '0, 3, "R3 still closed");
      step(IDLE_RD, 1'b1, D0, 1, "R1 processor read of 10");
      rst_n = 1'b0;
      step(IDLE_RD, 1'b0, '0, 10, "R10 pipeline cleared");
      rst_n = 1'b1;
      step(IDLE_RD, 1'b0, '0, 10, "R10 burst cleared");
      step(IDLE_RD, 1'b0, '0, 10, "R10 burst stays cleared");
      v = IDLE_RD; v.pn = 1'b0; v.a = 6'd11;
      step(v, 1'b0, '0, 10, "R10 idle before read");
      step(IDLE_RD, 1'b1, D1, 10, "R10 array kept");

      // R8: sleep freezes, then strobes ignored for two edges
      v = IDLE_RD; v.pn = 1'b0; v.a = 6'd8;
      step(v, 1'b1, D1, 4, "R4 suspend before sleep");
      sleep = 1'b1;
      v = IDLE_RD; v.cn = 1'b0; v.gwn = 1'b0; v.a = 6'd8; v.d = '0;
      step(v, 1'b0, '0, 8, "R8 sleep silences bus");
      v = IDLE_RD; v.pn = 1'b0; v.a = 6'd9;
      step(v, 1'b0, '0, 8, "R8 no access while asleep");
      sleep = 1'b0;
      step(v, 1'b0, '0, 8, "R8 first wake edge");
      step(v, 1'b1, D2, 8, "R8 strobe ignored, write in sleep ignored");
      step(v, 1'b1, D2, 8, "R8 strobe ignored second edge");
      step(IDLE_RD, 1'b1, W9, 8, "R8 strobe accepted third edge");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule